// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline. Each cycle it looks at the instruction now in execute and the instruction now in decode. It stalls when the execute instruction is a load and its destination register is one of the source registers that the decode instruction reads. Forwarding cannot serve that consumer, because the loaded value only exists after the memory stage.

On a stall the unit does three things in the same cycle. It holds the program counter. It holds the fetch/decode pipeline register, so fetch and decode repeat the same two instructions in the next cycle. It selects all-zero control fields for the decode/execute register, so that a bubble with no register or memory write moves downstream. Once the bubble has replaced the load in execute, the match disappears. Each load-use pair therefore costs exactly one cycle. Every other read-after-write case is left to the forwarding network.

The outputs are a pure function of the current pipeline register contents. The unit keeps no state of its own.

Top module: `ldu_hazard_unit`

## Requirements
- R1: When `ex_mem_read_i` is 1 and `ex_rt_i` is non-zero and equal to `id_rs_i`, the unit stalls: `ctrl_zero_o` = 1, `pc_we_o` = 0, `ifid_we_o` = 0.
- R2: When `ex_mem_read_i` is 1 and `ex_rt_i` is non-zero and equal to `id_rt_i`, the unit stalls in the same way.
- R3: When `ex_mem_read_i` is 0, the unit never stalls, whatever the register numbers are.
- R4: A destination of register 0 never causes a stall, even if a source register is also 0.
- R5: `pc_we_o` and `ifid_we_o` are always equal. Both are 1 when there is no stall and 0 during a stall, so fetch and decode repeat their instructions.
- R6: `ctrl_zero_o` is always the inverse of `pc_we_o`. It is 1 only while a stall is raised.
- R7: In a pipeline that inserts the bubble on `ctrl_zero_o`, each load followed directly by a consumer costs exactly one stall cycle. A consumer two or more instructions after the load costs none. A load with no consumer costs none. Every program instruction still enters execute exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_mem_read_i | input | 1 | Execute-stage instruction reads data memory (is a load) |
| ex_rt_i | input | 5 | Execute-stage load destination register number |
| id_rs_i | input | 5 | Decode-stage first source register number |
| id_rt_i | input | 5 | Decode-stage second source register number |
| pc_we_o | output | 1 | Program counter write enable, 0 holds the PC |
| ifid_we_o | output | 1 | Fetch/decode register write enable, 0 holds it |
| ctrl_zero_o | output | 1 | Selects zeroed control fields into the decode/execute register |

## Verification
Two detections can fire in the same cycle: the match on the first source and the match on the second source. This happens when a consumer reads the loaded register through both operands. Directed vectors and a pipeline-level program provoke it with both source fields equal to the load destination. The result must be a single stall flag and, in the pipeline model, exactly one lost cycle rather than two. Random vectors are biased so that each source matches the destination often. They also mix in register 0 and loads that are idle. The bench compares every output with a function built from the requirements.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned SRC_CNT   = 2;

  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic ctrl_zero;
  } stall_ctrl_t;
endpackage

// File: rtl/ldu_src_match.sv
module ldu_src_match #(
  parameter int unsigned REG_W = ldu_pkg::REG_IDX_W
) (
  input  logic [REG_W-1:0] dst_i,
  input  logic [REG_W-1:0] src_i,
  output logic             hit_o
);
  // register 0 is hardwired, never a real dependency
  logic dst_live;
  assign dst_live = |dst_i;
  assign hit_o    = dst_live && (dst_i == src_i);
endmodule

// File: rtl/ldu_stall_ctl.sv
module ldu_stall_ctl #(
  parameter int unsigned NUM_SRC = ldu_pkg::SRC_CNT
) (
  input  logic                  is_load_i,
  input  logic [NUM_SRC-1:0]    hit_i,
  output ldu_pkg::stall_ctrl_t  ctrl_o
);
  logic stall;
  assign stall = is_load_i && (|hit_i);

  always_comb begin
    ctrl_o.pc_we     = ~stall;
    ctrl_o.ifid_we   = ~stall;
    ctrl_o.ctrl_zero = stall;
  end
endmodule

// File: rtl/ldu_hazard_unit.sv
module ldu_hazard_unit #(
  parameter int unsigned REG_W   = ldu_pkg::REG_IDX_W,
  parameter int unsigned NUM_SRC = ldu_pkg::SRC_CNT
) (
  input  logic             ex_mem_read_i,
  input  logic [REG_W-1:0] ex_rt_i,
  input  logic [REG_W-1:0] id_rs_i,
  input  logic [REG_W-1:0] id_rt_i,
  output logic             pc_we_o,
  output logic             ifid_we_o,
  output logic             ctrl_zero_o
);
  logic [NUM_SRC-1:0][REG_W-1:0] src;
  logic [NUM_SRC-1:0]            hit;
  ldu_pkg::stall_ctrl_t          ctrl;

  always_comb begin
    src = '0;
    src[0] = id_rs_i;
    if (NUM_SRC > 1) src[NUM_SRC-1] = id_rt_i;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_match
    ldu_src_match #(.REG_W(REG_W)) i_match (
      .dst_i (ex_rt_i),
      .src_i (src[g]),
      .hit_o (hit[g])
    );
  end

  ldu_stall_ctl #(.NUM_SRC(NUM_SRC)) i_ctl (
    .is_load_i (ex_mem_read_i),
    .hit_i     (hit),
    .ctrl_o    (ctrl)
  );

  assign pc_we_o     = ctrl.pc_we;
  assign ifid_we_o   = ctrl.ifid_we;
  assign ctrl_zero_o = ctrl.ctrl_zero;
endmodule

// File: rtl/ldu_hazard_unit_chk.sv
module ldu_hazard_unit_chk #(
  parameter int unsigned REG_W = ldu_pkg::REG_IDX_W
) (
  input logic             ex_mem_read_i,
  input logic [REG_W-1:0] ex_rt_i,
  input logic [REG_W-1:0] id_rs_i,
  input logic [REG_W-1:0] id_rt_i,
  input logic             pc_we_o,
  input logic             ifid_we_o,
  input logic             ctrl_zero_o
);
  always_comb begin
    // R1
    rs_stall_chk: assert (!(ex_mem_read_i && ex_rt_i != '0 && ex_rt_i == id_rs_i) || ctrl_zero_o);
    // R2
    rt_stall_chk: assert (!(ex_mem_read_i && ex_rt_i != '0 && ex_rt_i == id_rt_i) || ctrl_zero_o);
    // R3
    no_load_no_stall_chk: assert (ex_mem_read_i || !ctrl_zero_o);
    // R4
    zero_reg_chk: assert (ex_rt_i != '0 || !ctrl_zero_o);
    // R5
    hold_pair_chk: assert (pc_we_o == ifid_we_o);
    // R6
    bubble_excl_chk: assert (ctrl_zero_o != pc_we_o);
  end
endmodule

bind ldu_hazard_unit ldu_hazard_unit_chk #(.REG_W(REG_W)) i_chk (.*);

// File: tb/test_ldu_hazard_unit.sv
module test_ldu_hazard_unit;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mr;
  logic [4:0] ert, rs, rt;
  logic       pc_we, ifid_we, czero;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ldu_hazard_unit i_ldu_hazard_unit (
    .ex_mem_read_i (mr),
    .ex_rt_i       (ert),
    .id_rs_i       (rs),
    .id_rt_i       (rt),
    .pc_we_o       (pc_we),
    .ifid_we_o     (ifid_we),
    .ctrl_zero_o   (czero)
  );

  function automatic bit exp_stall(bit m, logic [4:0] d, logic [4:0] a, logic [4:0] b);
    return m && (d != 5'd0) && (d == a || d == b);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(bit m, logic [4:0] d, logic [4:0] a, logic [4:0] b, string req);
    bit e;
    mr = m; ert = d; rs = a; rt = b;
    @(negedge clk);
    e = exp_stall(m, d, a, b);
    check(czero == e, req, int'(czero), int'(e));
    check(pc_we == !e && ifid_we == !e, "R5", int'({pc_we, ifid_we}), int'({!e, !e}));
    check(czero == !pc_we, "R6", int'(czero), int'(!pc_we));
  endtask

  // pipeline model: program of {is_load, dst, src_a, src_b}
  bit         p_ld [8];
  logic [4:0] p_d  [8];
  logic [4:0] p_a  [8];
  logic [4:0] p_b  [8];
  int         p_len;

  task automatic set_i(int i, bit l, int d, int a, int b);
    p_ld[i] = l; p_d[i] = 5'(d); p_a[i] = 5'(a); p_b[i] = 5'(b);
  endtask

  function automatic int exp_stalls();
    int n = 0;
    for (int i = 0; i + 1 < p_len; i++)
      if (exp_stall(p_ld[i], p_d[i], p_a[i+1], p_b[i+1])) n++;
    return n;
  endfunction

  task automatic run_prog(string name);
    int pc = 0;
    bit fv = 0, ev = 0, f_ld = 0, e_ld = 0;
    logic [4:0] f_a = 0, f_b = 0, f_d = 0, e_d = 0;
    int stalls = 0, issued = 0;
    bit st, w;
    mr = 0; ert = 0; rs = 0; rt = 0;
    for (int cyc = 0; cyc < p_len * 3 + 6; cyc++) begin
      @(negedge clk);
      st = czero;
      w  = ifid_we;
      if (st) stalls++;
      @(posedge clk);
      if (st) begin
        ev = 0; e_ld = 0; e_d = 0;
      end else begin
        ev = fv; e_ld = f_ld; e_d = f_d;
        if (fv) issued++;
      end
      if (w) begin
        if (pc < p_len) begin
          fv = 1; f_ld = p_ld[pc]; f_d = p_d[pc]; f_a = p_a[pc]; f_b = p_b[pc];
          pc++;
        end else begin
          fv = 0; f_ld = 0; f_d = 0; f_a = 0; f_b = 0;
        end
      end
      mr = ev && e_ld; ert = e_d; rs = f_a; rt = f_b;
    end
    check(stalls == exp_stalls(), {"R7 stalls ", name}, stalls, exp_stalls());
    check(issued == p_len, {"R7 issued ", name}, issued, p_len);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, -1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit m;
    logic [4:0] d, a, b;
    void'($urandom(32'h5eed_0042));
    mr = 0; ert = 0; rs = 0; rt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pc_we && ifid_we && !czero, "R5 reset", int'({pc_we, ifid_we, czero}), 6);
    rst_ni = 1'b1;

    apply(1, 5'd9,  5'd9,  5'd3,  "R1");
    apply(1, 5'd12, 5'd1,  5'd12, "R2");
    apply(1, 5'd17, 5'd17, 5'd17, "R1 R2 both");
    apply(0, 5'd9,  5'd9,  5'd9,  "R3");
    apply(1, 5'd0,  5'd0,  5'd0,  "R4");
    apply(1, 5'd0,  5'd0,  5'd4,  "R4");
    apply(1, 5'd31, 5'd30, 5'd29, "R1 miss");

    for (int i = 0; i < 400; i++) begin
      m = 1'($urandom);
      d = 5'($urandom);
      if ($urandom % 8 == 0) d = 5'd0;
      a = ($urandom % 3 == 0) ? d : 5'($urandom);
      b = ($urandom % 3 == 0) ? d : 5'($urandom);
      apply(m, d, a, b, (a == d) ? "R1 rnd" : (b == d) ? "R2 rnd" : "R3 rnd");
    end

    // direct use
    p_len = 3; set_i(0, 1, 5, 0, 0); set_i(1, 0, 8, 5, 2); set_i(2, 0, 9, 1, 1);
    run_prog("direct");
    // use two later
    p_len = 3; set_i(0, 1, 5, 0, 0); set_i(1, 0, 8, 1, 2); set_i(2, 0, 9, 5, 5);
    run_prog("gap");
    // load r0 then use r0
    p_len = 2; set_i(0, 1, 0, 0, 0); set_i(1, 0, 8, 0, 0);
    run_prog("r0");
    // both sources read the loaded register
    p_len = 2; set_i(0, 1, 7, 0, 0); set_i(1, 0, 8, 7, 7);
    run_prog("both");
    // load chain then use
    p_len = 3; set_i(0, 1, 3, 0, 0); set_i(1, 1, 4, 3, 0); set_i(2, 0, 6, 0, 4);
    run_prog("chain");
    // load with no consumer
    p_len = 2; set_i(0, 1, 6, 0, 0); set_i(1, 0, 8, 1, 2);
    run_prog("noconsumer");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule